// File: doc/BRIEF.md
# Millisecond Real-Time Counter with Seconds Snapshot

This block keeps wall-clock time in an always-on domain that continues to run while the rest of the chip sleeps. It holds two counts. The first is a milliseconds-within-second count, advanced by a 1 kHz tick enable. The second is a seconds count that advances each time the millisecond count wraps. Both counts are exposed through a small read-only register port, so the counter can serve as a persistent, monotonic time base.

A bus read can fetch only one word at a time, so a time value split across two registers could be torn. The block avoids this with a snapshot. Any read of the milliseconds word also copies the live seconds count into a separate snapshot register at the same clock edge. Software reads milliseconds first and then the snapshot. It then forms the time as seconds × 1000 + milliseconds, and the pair always describes the same instant.

Top module: `msec_rtc`

## Requirements
- R1: After reset the millisecond count, the live seconds, the snapshot seconds and `rd_valid` are all 0.
- R2: At each clock edge where `tick_ms` is 1 and the millisecond count is below `MS_PER_SEC-1`, the millisecond count rises by one. When `tick_ms` is 0, both counts hold.
- R3: At an edge where `tick_ms` is 1 and the millisecond count equals `MS_PER_SEC-1`, the millisecond count becomes 0 and the live seconds rise by one at that same edge.
- R4: The live seconds are `SEC_W` bits wide (32 by default) and wrap modulo 2^`SEC_W`.
- R5: A read is a one-cycle pulse on `rd_en` with `rd_addr`. On the following cycle, `rd_valid` is 1 and `rd_data` carries the word. With no read, `rd_valid` is 0 on the next cycle. Address `MS_OFS` (0x10) returns the millisecond count as it stood before the read edge.
- R6: The edge that samples a read of `MS_OFS` also loads the snapshot register with the live seconds as they stood before that edge. Address `SHD_OFS` (0x0c) returns the snapshot register.
- R7: Address `SEC_OFS` (0x08) returns the live seconds as they stood before the read edge. The value is zero-extended to 32 bits.
- R8: The snapshot register changes only on a read of `MS_OFS`. Ticks, rollovers and reads of any other address leave it unchanged.
- R9: A read of any address other than 0x08, 0x0c and 0x10 returns 0.
- R10: When a read of `MS_OFS` coincides with a rollover edge, the returned milliseconds (`MS_PER_SEC-1`) and the snapshot both come from before the increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on domain clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_ms | input | 1 | One-cycle enable at 1 kHz; advances the millisecond count |
| rd_en | input | 1 | Read strobe, one cycle per read |
| rd_addr | input | ADDR_W | Byte offset of the word read |
| rd_data | output | 32 | Read word, valid while `rd_valid` is 1 |
| rd_valid | output | 1 | Marks the cycle that carries the read word |

## Verification
The counts and the snapshot change at the clock edge that samples a tick or a read. A read word appears on `rd_data` one cycle after the `rd_en` pulse and reflects the register state from before that edge. The bench drives inputs on the falling edge and keeps its own model, which it advances once per rising edge. It computes the expected word from the model before that edge, samples the outputs 1 ns after the edge, and compares them with that expected word. A reduced configuration (5 ms per second, 4-bit seconds) lets a sweep pass several seconds wraps. This sweep covers every millisecond phase, reads at every mapped and unmapped address, and a read that lands on a rollover edge.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  typedef enum logic [1:0] {
    SEL_NONE   = 2'd0,
    SEL_LIVE   = 2'd1,
    SEL_SHADOW = 2'd2,
    SEL_MSEC   = 2'd3
  } rtc_sel_e;

  // true when the millisecond count sits on its last value of a second
  function automatic logic ms_at_last(input logic [31:0] cur, input logic [31:0] last);
    return cur == last;
  endfunction

  // millisecond successor under the tick, wrapping after the last value
  function automatic logic [31:0] ms_follow(input logic [31:0] cur, input logic [31:0] last);
    return ms_at_last(cur, last) ? 32'd0 : cur + 32'd1;
  endfunction

  // map a byte offset onto a register selection
  function automatic rtc_sel_e decode_offset(input logic [31:0] addr,
                                             input logic [31:0] sec_ofs,
                                             input logic [31:0] shd_ofs,
                                             input logic [31:0] ms_ofs);
    if (addr == sec_ofs) return SEL_LIVE;
    if (addr == shd_ofs) return SEL_SHADOW;
    if (addr == ms_ofs)  return SEL_MSEC;
    return SEL_NONE;
  endfunction

endpackage

// File: rtl/rtc_ms_counter.sv
module rtc_ms_counter #(
  parameter int MS_PER_SEC = 1000,
  parameter int MS_W       = $clog2(MS_PER_SEC)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick_i,
  output logic [MS_W-1:0] ms_o,
  output logic            carry_o
);
  localparam logic [31:0] LAST = 32'(MS_PER_SEC - 1);

  logic [MS_W-1:0] ms_q;

  assign carry_o = tick_i && rtc_pkg::ms_at_last(32'(ms_q), LAST);
  assign ms_o    = ms_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      ms_q <= '0;
    else if (tick_i) ms_q <= MS_W'(rtc_pkg::ms_follow(32'(ms_q), LAST));
  end
endmodule

// File: rtl/rtc_sec_counter.sv
module rtc_sec_counter #(
  parameter int SEC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_i,
  output logic [SEC_W-1:0] sec_o
);
  logic [SEC_W-1:0] sec_q;

  assign sec_o = sec_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      sec_q <= '0;
    else if (step_i) sec_q <= sec_q + SEC_W'(1);
  end
endmodule

// File: rtl/rtc_shadow.sv
module rtc_shadow #(
  parameter int SEC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [SEC_W-1:0] sec_i,
  output logic [SEC_W-1:0] shadow_o
);
  logic [SEC_W-1:0] shadow_q;

  assign shadow_o = shadow_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      shadow_q <= '0;
    else if (load_i) shadow_q <= sec_i;
  end
endmodule

// File: rtl/rtc_rd_port.sv
module rtc_rd_port #(
  parameter int          SEC_W   = 32,
  parameter int          MS_W    = 10,
  parameter int          ADDR_W  = 8,
  parameter int          DATA_W  = 32,
  parameter logic [31:0] SEC_OFS = 32'h08,
  parameter logic [31:0] SHD_OFS = 32'h0c,
  parameter logic [31:0] MS_OFS  = 32'h10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [MS_W-1:0]   ms_i,
  input  logic [SEC_W-1:0]  sec_i,
  input  logic [SEC_W-1:0]  shadow_i,
  output logic              snap_o,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  rtc_pkg::rtc_sel_e sel;
  logic [DATA_W-1:0] sec_ext, shd_ext, ms_ext, word;

  generate
    if (SEC_W < DATA_W) begin : g_pad
      assign sec_ext = {{(DATA_W-SEC_W){1'b0}}, sec_i};
      assign shd_ext = {{(DATA_W-SEC_W){1'b0}}, shadow_i};
    end else begin : g_cut
      assign sec_ext = sec_i[DATA_W-1:0];
      assign shd_ext = shadow_i[DATA_W-1:0];
    end
  endgenerate

  assign ms_ext = DATA_W'(ms_i);
  assign sel    = rtc_pkg::decode_offset(32'(rd_addr), SEC_OFS, SHD_OFS, MS_OFS);
  assign snap_o = rd_en && (sel == rtc_pkg::SEL_MSEC);

  always_comb begin
    unique case (sel)
      rtc_pkg::SEL_LIVE:   word = sec_ext;
      rtc_pkg::SEL_SHADOW: word = shd_ext;
      rtc_pkg::SEL_MSEC:   word = ms_ext;
      default:             word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= word;
    end
  end
endmodule

// File: rtl/msec_rtc.sv
module msec_rtc #(
  parameter int          MS_PER_SEC = 1000,
  parameter int          SEC_W      = 32,
  parameter int          ADDR_W     = 8,
  parameter logic [31:0] SEC_OFS    = 32'h08,
  parameter logic [31:0] SHD_OFS    = 32'h0c,
  parameter logic [31:0] MS_OFS     = 32'h10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_ms,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  output logic              rd_valid
);
  localparam int MS_W   = $clog2(MS_PER_SEC);
  localparam int DATA_W = 32;

  // named internal events for the checker
  logic [MS_W-1:0]  ms_q;
  logic [SEC_W-1:0] sec_q;
  logic [SEC_W-1:0] shadow_q;
  logic             sec_step;
  logic             snap_ev;

  rtc_ms_counter #(.MS_PER_SEC(MS_PER_SEC), .MS_W(MS_W)) u_ms (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_ms), .ms_o(ms_q), .carry_o(sec_step));

  rtc_sec_counter #(.SEC_W(SEC_W)) u_sec (
    .clk(clk), .rst_n(rst_n), .step_i(sec_step), .sec_o(sec_q));

  rtc_shadow #(.SEC_W(SEC_W)) u_shd (
    .clk(clk), .rst_n(rst_n), .load_i(snap_ev), .sec_i(sec_q), .shadow_o(shadow_q));

  rtc_rd_port #(
    .SEC_W(SEC_W), .MS_W(MS_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .SEC_OFS(SEC_OFS), .SHD_OFS(SHD_OFS), .MS_OFS(MS_OFS)
  ) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
    .ms_i(ms_q), .sec_i(sec_q), .shadow_i(shadow_q),
    .snap_o(snap_ev), .rd_data(rd_data), .rd_valid(rd_valid));
endmodule

// File: rtl/msec_rtc_chk.sv
module msec_rtc_chk #(
  parameter int          MS_PER_SEC = 1000,
  parameter int          SEC_W      = 32,
  parameter int          ADDR_W     = 8,
  parameter int          MS_W       = 10,
  parameter logic [31:0] SEC_OFS    = 32'h08,
  parameter logic [31:0] SHD_OFS    = 32'h0c,
  parameter logic [31:0] MS_OFS     = 32'h10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_ms,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [31:0]       rd_data,
  input logic              rd_valid,
  input logic [MS_W-1:0]   ms_q,
  input logic [SEC_W-1:0]  sec_q,
  input logic [SEC_W-1:0]  shadow_q,
  input logic              sec_step,
  input logic              snap_ev
);
  localparam logic [MS_W-1:0] LAST = MS_W'(MS_PER_SEC - 1);

  logic unmapped;
  assign unmapped = (32'(rd_addr) != SEC_OFS) && (32'(rd_addr) != SHD_OFS) &&
                    (32'(rd_addr) != MS_OFS);

  // R2
  ms_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_ms && ms_q != LAST) |=> (ms_q == $past(ms_q) + MS_W'(1)));
  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_ms |=> ($stable(ms_q) && $stable(sec_q)));
  // R3
  rollover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_ms && ms_q == LAST) |=> (ms_q == '0 && sec_q == $past(sec_q) + SEC_W'(1)));
  // R2
  ms_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ms_q <= LAST);
  // R5
  valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid == $past(rd_en));
  // R6
  snap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snap_ev |=> (shadow_q == $past(sec_q)));
  // R8
  shadow_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !snap_ev |=> $stable(shadow_q));
  // R9
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && unmapped) |=> (rd_data == 32'd0));
  // R10
  coincide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_step && snap_ev) |=> (rd_data == 32'(LAST) && shadow_q == $past(sec_q)));
endmodule

bind msec_rtc msec_rtc_chk #(
  .MS_PER_SEC(MS_PER_SEC), .SEC_W(SEC_W), .ADDR_W(ADDR_W), .MS_W(MS_W),
  .SEC_OFS(SEC_OFS), .SHD_OFS(SHD_OFS), .MS_OFS(MS_OFS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .rd_en(rd_en), .rd_addr(rd_addr),
  .rd_data(rd_data), .rd_valid(rd_valid), .ms_q(ms_q), .sec_q(sec_q),
  .shadow_q(shadow_q), .sec_step(sec_step), .snap_ev(snap_ev));

// File: tb/sim_msec_rtc.sv
`timescale 1ns/1ps
module sim_msec_rtc;
  localparam int MSPS = 5;
  localparam int SW   = 4;
  localparam int AW   = 8;
  localparam logic [AW-1:0] A_SEC = 8'h08, A_SHD = 8'h0c, A_MS = 8'h10;

  logic clk = 1'b0, rst_n = 1'b0, tick_ms = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [31:0] rd_data;
  logic rd_valid;

  int total = 0, bad = 0;
  int m_ms = 0, m_sec = 0, m_shd = 0;

  always #5 clk = ~clk;

  msec_rtc #(.MS_PER_SEC(MSPS), .SEC_W(SW), .ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expect_word(input logic [AW-1:0] a);
    if (a == A_SEC) return m_sec;
    if (a == A_SHD) return m_shd;
    if (a == A_MS)  return m_ms;
    return 0;
  endfunction

  function automatic string tag_of(input logic [AW-1:0] a);
    if (a == A_SEC) return "R7 live seconds";
    if (a == A_SHD) return "R6 snapshot";
    if (a == A_MS)  return "R5 milliseconds";
    return "R9 unmapped";
  endfunction

  // one cycle: drive on falling edge, advance model, check after rising edge
  task automatic step(input logic t, input logic r, input logic [AW-1:0] a,
                      input string tag);
    int exp_w;
    @(negedge clk);
    tick_ms = t; rd_en = r; rd_addr = a;
    exp_w = expect_word(a);
    if (r && a == A_MS) m_shd = m_sec;
    if (t) begin
      if (m_ms == MSPS - 1) begin
        m_ms = 0;
        m_sec = (m_sec + 1) % (1 << SW);
      end else m_ms = m_ms + 1;
    end
    @(posedge clk); #1;
    check("R5 valid", 32'(rd_valid), 32'(r));
    if (r) check(tag, rd_data, 32'(exp_w));
    @(negedge clk);
    tick_ms = 1'b0; rd_en = 1'b0;
  endtask

  initial begin
    #2_000_000;
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1 check("R1 valid after reset", 32'(rd_valid), 32'd0);
    step(0, 1, A_MS,  "R1 ms reset");
    step(0, 1, A_SEC, "R1 sec reset");
    step(0, 1, A_SHD, "R1 shadow reset");

    // R2: three ticks, then hold without tick
    for (int i = 0; i < 3; i++) step(1, 0, A_SEC, "R2");
    step(0, 1, A_MS, "R2 count after 3 ticks");
    check("R2 model", 32'(m_ms), 32'd3);
    step(0, 0, A_SEC, "R2");
    step(0, 1, A_MS, "R2 hold without tick");

    // R3: rollover into seconds
    step(1, 0, A_SEC, "R3");
    step(1, 0, A_SEC, "R3");
    step(0, 1, A_MS,  "R3 ms after rollover");
    step(0, 1, A_SEC, "R3 sec after rollover");

    // R8: snapshot untouched by ticks and other reads
    step(0, 1, A_MS, "R6 snap at sec=1");
    for (int i = 0; i < MSPS; i++) step(1, 1, A_SEC, "R8 live while ticking");
    step(0, 1, A_SHD, "R8 snapshot kept");
    step(0, 1, 8'h04, "R9 unmapped 0x04");
    step(0, 1, A_SHD, "R8 snapshot kept after unmapped read");

    // R10: read of ms on the rollover edge
    while (m_ms != MSPS - 1) step(1, 0, A_SEC, "R10 setup");
    step(1, 1, A_MS, "R10 ms before increment");
    step(0, 1, A_SHD, "R10 snapshot before increment");
    step(0, 1, A_SEC, "R10 live after increment");

    // R4: run seconds through their wrap
    while (m_sec != (1 << SW) - 1) step(1, 0, A_SEC, "R4 setup");
    while (m_ms != 0) step(1, 0, A_SEC, "R4 setup");
    step(0, 1, A_SEC, "R4 seconds at max");
    for (int i = 0; i < MSPS; i++) step(1, 0, A_SEC, "R4");
    step(0, 1, A_SEC, "R4 seconds wrapped");
    check("R4 model wrap", 32'(m_sec), 32'd0);

    // sweep: every phase, every address, mixed ticks, past two wraps
    for (int i = 0; i < 2 * MSPS * (1 << SW) * 2; i++) begin
      logic [AW-1:0] a;
      case (i % 6)
        0: a = A_MS; 1: a = A_SHD; 2: a = A_SEC;
        3: a = 8'h14; 4: a = 8'h00; default: a = A_MS;
      endcase
      step(logic'(i % 4 != 3), logic'(i % 5 != 4), a, tag_of(a));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule